// File: doc/BRIEF.md
# Receive FIFO with Level-Driven RTS Hysteresis

This block sits between a serial receiver's shifter and the register read port of a serial port. Received bytes enter on a push strobe and leave on a pop strobe. The byte at the head of the queue is always visible on the read data port. The block reports its fill level, its full and empty state, and a sticky overrun flag. The overrun flag is set when a byte arrives while the queue is full and nothing leaves in the same cycle.

The RTS handshake line is normally driven from the fill level with two software thresholds, a low mark and a high mark:

- When the level climbs to the high mark from below, RTS goes high, which asks the peer to pause.
- When the level drops to the low mark from above, RTS goes low, which invites the peer to send again.
- Between these two crossing events, RTS keeps its last value.

When the enable input is clear, RTS is taken from a legacy source instead. The hysteresis state keeps tracking the level the whole time.

Top module: `rx_level_fifo`

## Requirements
- R1: After reset the level is 0, empty is 1, full is 0, overrun is 0, and the level-driven RTS state is low.
- R2: Bytes (8 bits each) are read out in the order they were accepted, and the head byte is shown on popData whenever the queue is not empty.
- R3: An accepted push raises the level by one and an accepted pop lowers it by one. Both in the same cycle leave it unchanged. The level never exceeds DEPTH.
- R4: A push while full with no pop in the same cycle is dropped: the level and contents are unchanged and overrun becomes 1. A push while full together with a pop is accepted.
- R5: overrun stays 1 until overrunClr is pulsed. If a drop and a clear happen in the same cycle, overrun stays 1.
- R6: A pop while empty is ignored and the level stays 0.
- R7: When the level moves from below highMark to a value at or above highMark, the level-driven RTS state becomes 1 on that same clock edge.
- R8: When the level moves from above lowMark to a value at or below lowMark, the level-driven RTS state becomes 0 on that same clock edge.
- R9: Any other change in level leaves the level-driven RTS state unchanged.
- R10: While fifoRtsEn is 1, rts shows the level-driven state. While it is 0, rts equals legacyRts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Byte arriving from the receiver |
| pushData | input | 8 | Arriving byte |
| popReq | input | 1 | Remove the head byte |
| popData | output | 8 | Head byte |
| fifoLevel | output | $clog2(DEPTH+1) | Current number of stored bytes |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level equals 0 |
| overrunClr | input | 1 | Clear pulse for the overrun flag |
| overrun | output | 1 | Sticky dropped-byte flag |
| lowMark | input | $clog2(DEPTH+1) | Low threshold |
| highMark | input | $clog2(DEPTH+1) | High threshold |
| fifoRtsEn | input | 1 | Select level-driven RTS |
| legacyRts | input | 1 | RTS source used when level control is off |
| rts | output | 1 | RTS line |

## Verification
The assertions assume three things about the inputs:

- lowMark does not exceed highMark.
- Both thresholds are within 0 to DEPTH.
- The thresholds are only rewritten while no crossing is pending.

Under these assumptions, the threshold-crossing properties state exactly which single push or pop must set or clear the RTS state. The stimulus meets these assumptions by sweeping every ordered pair with low not greater than high over a depth-8 instance. It changes the pair only while the queue is empty, then fills the queue to the top and drains it to zero, so that every crossing point is passed in both directions.

// File: rtl/rxff_pkg.sv
package rxff_pkg;
  typedef struct packed {
    logic doWrite;
    logic doRead;
  } strobe_t;
endpackage

// File: rtl/rxff_data.sv
module rxff_data #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxff_pkg::strobe_t strb,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.doWrite) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (strb.doRead)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.doWrite) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= LAST) && (rdPtr <= LAST)); // R2
endmodule

// File: rtl/rxff_ctrl.sv
module rxff_ctrl #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic              popReq,
  input  logic              overrunClr,
  input  logic [LW-1:0]     lowMark,
  input  logic [LW-1:0]     highMark,
  input  logic              fifoRtsEn,
  input  logic              legacyRts,
  output rxff_pkg::strobe_t strb,
  output logic [LW-1:0]     fifoLevel,
  output logic              full,
  output logic              empty,
  output logic              overrun,
  output logic              rts
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);

  logic          popAcc, pushAcc, dropNow;
  logic [LW-1:0] nextLevel;
  logic          riseHit, fallHit;
  logic          rtsHyst;

  assign empty   = (fifoLevel == '0);
  assign full    = (fifoLevel == TOP);
  assign popAcc  = popReq && !empty;
  assign pushAcc = pushValid && (!full || popAcc);
  assign dropNow = pushValid && !pushAcc;

  assign strb.doWrite = pushAcc;
  assign strb.doRead  = popAcc;

  always_comb begin
    nextLevel = fifoLevel;
    if (pushAcc && !popAcc) nextLevel = fifoLevel + 1'b1;
    if (popAcc && !pushAcc) nextLevel = fifoLevel - 1'b1;
  end

  assign riseHit = (fifoLevel < highMark) && (nextLevel >= highMark);
  assign fallHit = (fifoLevel > lowMark)  && (nextLevel <= lowMark);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoLevel <= '0;
      overrun   <= 1'b0;
      rtsHyst   <= 1'b0;
    end else begin
      fifoLevel <= nextLevel;
      if (dropNow)         overrun <= 1'b1;
      else if (overrunClr) overrun <= 1'b0;
      if (riseHit)         rtsHyst <= 1'b1;
      else if (fallHit)    rtsHyst <= 1'b0;
    end
  end

  assign rts = fifoRtsEn ? rtsHyst : legacyRts;

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= TOP); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !empty && pushValid) |=> $stable(fifoLevel)); // R3
  AST_NO_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && full && !popReq) |=> (overrun && $stable(fifoLevel))); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !overrunClr) |=> overrun); // R5
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty && !pushValid) |=> (fifoLevel == '0)); // R6
  AST_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !popReq && !full && ({1'b0, fifoLevel} + 1'b1 == {1'b0, highMark}))
      |=> rtsHyst); // R7
  AST_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushValid && !empty && ({1'b0, fifoLevel} == {1'b0, lowMark} + 1'b1))
      |=> !rtsHyst); // R8
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!pushValid && !popReq) |=> $stable(rtsHyst)); // R9
endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushValid,
  input  logic [7:0]    pushData,
  input  logic          popReq,
  output logic [7:0]    popData,
  output logic [LW-1:0] fifoLevel,
  output logic          full,
  output logic          empty,
  input  logic          overrunClr,
  output logic          overrun,
  input  logic [LW-1:0] lowMark,
  input  logic [LW-1:0] highMark,
  input  logic          fifoRtsEn,
  input  logic          legacyRts,
  output logic          rts
);
  rxff_pkg::strobe_t strb;

  rxff_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .popReq(popReq),
    .overrunClr(overrunClr), .lowMark(lowMark), .highMark(highMark),
    .fifoRtsEn(fifoRtsEn), .legacyRts(legacyRts), .strb(strb),
    .fifoLevel(fifoLevel), .full(full), .empty(empty),
    .overrun(overrun), .rts(rts)
  );

  rxff_data #(.DEPTH(DEPTH), .DW(8)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(pushData), .rdData(popData)
  );
endmodule

// File: tb/rx_level_fifo_test.sv
module rx_level_fifo_test;
  localparam int D = 8;
  localparam int LW = $clog2(D + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, popReq = 1'b0, overrunClr = 1'b0;
  logic fifoRtsEn = 1'b1, legacyRts = 1'b0;
  logic [7:0] pushData = '0;
  logic [LW-1:0] lowMark = '0, highMark = '0;
  logic [7:0] popData;
  logic [LW-1:0] fifoLevel;
  logic full, empty, overrun, rts;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0] q [D];
  int qHead = 0, qCnt = 0;
  logic expRts = 1'b0, expOvr = 1'b0;

  always #4 clk = ~clk;

  rx_level_fifo #(.DEPTH(D)) uut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .popReq(popReq), .popData(popData), .fifoLevel(fifoLevel), .full(full),
    .empty(empty), .overrunClr(overrunClr), .overrun(overrun),
    .lowMark(lowMark), .highMark(highMark), .fifoRtsEn(fifoRtsEn),
    .legacyRts(legacyRts), .rts(rts)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [7:0] d,
                      input logic clr);
    bit pa, ua;
    int prev;
    string rtag;
    @(negedge clk);
    if (qCnt > 0) chk("R2 head data", popData, q[qHead]);
    pushValid = pu; popReq = po; pushData = d; overrunClr = clr;
    pa = po && (qCnt > 0);
    ua = pu && ((qCnt < D) || pa);
    prev = qCnt;
    if (pa) begin qHead = (qHead + 1) % D; qCnt--; end
    if (ua) begin q[(qHead + qCnt) % D] = d; qCnt++; end
    if (pu && !ua) expOvr = 1'b1;
    else if (clr) expOvr = 1'b0;
    rtag = "R9 rts hold";
    if (prev < highMark && qCnt >= highMark) begin expRts = 1'b1; rtag = "R7 rts rise"; end
    else if (prev > lowMark && qCnt <= lowMark) begin expRts = 1'b0; rtag = "R8 rts fall"; end
    @(posedge clk);
    #1;
    pushValid = 1'b0; popReq = 1'b0; overrunClr = 1'b0;
    chk("R3 level", fifoLevel, qCnt);
    chk(pu && !ua ? "R4 overrun set" : "R5 overrun", overrun, expOvr);
    chk("R4 full flag", full, qCnt == D);
    if (fifoRtsEn) chk(rtag, rts, expRts);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 level", fifoLevel, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rts", rts, 0);
    rstN = 1'b1;

    // R6: pop on empty
    step(1'b0, 1'b1, 8'h00, 1'b0);
    chk("R6 empty stays", empty, 1);

    // sweep every threshold pair, fill then drain (R2 R3 R7 R8 R9)
    for (int lo = 0; lo <= D; lo++) begin
      for (int hi = lo; hi <= D; hi++) begin
        @(negedge clk);
        lowMark = LW'(lo); highMark = LW'(hi);
        for (int k = 0; k < D; k++) step(1'b1, 1'b0, 8'((lo * 37) ^ (hi * 11) ^ (k * 29)), 1'b0);
        for (int k = 0; k < D; k++) step(1'b0, 1'b1, 8'h00, 1'b0);
      end
    end

    // mid-range hold with simultaneous push/pop (R3 R9)
    @(negedge clk); lowMark = 2; highMark = 6;
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'(k + 8'h40), 1'b0);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 8'(k + 8'h50), 1'b0);

    // overrun behaviour (R4 R5)
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'(k + 8'h60), 1'b0);
    step(1'b1, 1'b0, 8'hEE, 1'b0);          // dropped
    step(1'b1, 1'b1, 8'hA5, 1'b0);          // accepted at full with pop
    step(1'b0, 1'b0, 8'h00, 1'b1);          // clear
    step(1'b1, 1'b0, 8'hEF, 1'b1);          // drop wins over clear
    step(1'b0, 1'b0, 8'h00, 1'b1);
    for (int k = 0; k < D; k++) step(1'b0, 1'b1, 8'h00, 1'b0);
    step(1'b0, 1'b1, 8'h00, 1'b0);          // R6

    // legacy source (R10)
    @(negedge clk); fifoRtsEn = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); legacyRts = k[0];
      #1; chk("R10 legacy rts", rts, k);
    end
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 8'(k), 1'b0); // crosses high 6
    @(negedge clk); legacyRts = 1'b0; fifoRtsEn = 1'b1;
    #1; chk("R10 level rts restored", rts, expRts);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule